// File: doc/BRIEF.md
# Command transaction sequencer

This block is a hardware master that runs one complete command exchange with a microcontroller through a 16-bit mailbox data port. A requester presents an opcode, up to eight argument bytes with their count, and the number of response bytes it expects, then pulses `start`. The sequencer clears any stale mailbox status, writes the opcode and the arguments, consumes one acknowledge byte, and then collects the response bytes.

Every byte transfer waits on a mailbox status bit. The bit is transmit-not-full for writes and receive-not-empty for reads. Each wait is bounded by a poll limit, so a silent microcontroller cannot hang the block. On completion the block pulses `done`. It then presents the acknowledge value, the response bytes, the first two response bytes packed as a 16-bit word, and a timeout flag.

Top module: `cmd_seq`

## Requirements
- R1: After a start, the mailbox sees, in this order: the opcode write, every argument byte written from byte 0 upward, one acknowledge read, and then the response reads from byte 0 upward.
- R2: Outgoing bytes are written in bits 15:8 of `mb_data_wdata`, and bits 7:0 are zero. Incoming bytes are taken from bits 15:8 of `mb_data_rdata`, and bits 7:0 are ignored.
- R3: A data write is issued only in a cycle where `mb_stat[1]` (transmit not full) is 1. A data read is issued only in a cycle where `mb_stat[2]` (receive not empty) is 1.
- R4: The cycle after each data read, the block writes `4'b0100` to the status port, which clears receive-not-empty.
- R5: The first mailbox access after a start is a status write whose value equals `mb_stat` as read in that cycle. This writes back any stale condition, such as the overflow bit 3, to clear it.
- R6: The acknowledge byte appears on `ack_byte` and is not counted in the response length. Response byte i appears at `rsp_bytes[8i+7:8i]`, and `rsp_word` is {byte 0, byte 1}. Response bytes that were not received read as zero.
- R7: Zero argument bytes and zero response bytes are legal. With both at zero, only the opcode write and the acknowledge read take place.
- R8: An argument or response count above 8 is treated as 8.
- R9: If a wait sees POLL_LIMIT consecutive cycles without its status bit set, the transaction aborts. The block then pulses `done` with `timeout_err` = 1 and returns to idle. `timeout_err` holds until the next accepted start. A wait that is shorter than POLL_LIMIT cycles does not abort.
- R10: A `start` that arrives while `busy` is 1 is ignored.
- R11: `done` is a single-cycle pulse, given once per accepted start. `busy` is 1 from the cycle after the start until the cycle in which `done` is 1.
- R12: After reset, `busy`, `done`, `timeout_err`, `ack_byte` and `rsp_bytes` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transaction (accepted when idle) |
| opcode | input | 8 | Command opcode |
| arg_cnt | input | 4 | Number of argument bytes |
| arg_bytes | input | 64 | Argument byte i in bits 8i+7:8i |
| rsp_cnt | input | 4 | Number of response bytes expected |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout_err | output | 1 | Last transaction aborted on a poll timeout |
| ack_byte | output | 8 | Acknowledge byte received |
| rsp_bytes | output | 64 | Response byte i in bits 8i+7:8i |
| rsp_word | output | 16 | First response byte in bits 15:8, second in bits 7:0 |
| mb_stat | input | 4 | Mailbox status: bit1 transmit not full, bit2 receive not empty, bit3 overflow |
| mb_stat_wr | output | 1 | Status write strobe (write 1 to clear) |
| mb_stat_wdata | output | 4 | Status write value |
| mb_data_wr | output | 1 | Data write strobe |
| mb_data_wdata | output | 16 | Data write word |
| mb_data_rd | output | 1 | Data read strobe (takes one byte) |
| mb_data_rdata | input | 16 | Data read word |

## Verification
Two mailbox actions can compete for the same cycle. The first is a receive-status clear that follows a read. The second is the next byte transfer, which may already be ready, because the bench model can offer the next byte with no delay. The bench runs every pair of argument and response counts from 0 to 8 with varying receive delays. Across those runs it checks that exactly one clear is counted per byte taken and that every response byte lands in its own slot. A second overlap occurs when `start` is pulsed in the middle of a transaction. In that case the bench judges by the mailbox log and the `done` count that the running exchange went on unchanged.

// File: rtl/cmd_seq.sv
module cmd_seq #(
  parameter int MAX_BYTES  = 8,
  parameter int POLL_LIMIT = 10000,
  localparam int CW = $clog2(MAX_BYTES + 1),
  localparam int IW = CW + 1,
  localparam int AW = 8 * MAX_BYTES,
  localparam int PW = $clog2(POLL_LIMIT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [7:0]    opcode,
  input  logic [CW-1:0] arg_cnt,
  input  logic [AW-1:0] arg_bytes,
  input  logic [CW-1:0] rsp_cnt,
  output logic          busy,
  output logic          done,
  output logic          timeout_err,
  output logic [7:0]    ack_byte,
  output logic [AW-1:0] rsp_bytes,
  output logic [15:0]   rsp_word,
  input  logic [3:0]    mb_stat,
  output logic          mb_stat_wr,
  output logic [3:0]    mb_stat_wdata,
  output logic          mb_data_wr,
  output logic [15:0]   mb_data_wdata,
  output logic          mb_data_rd,
  input  logic [15:0]   mb_data_rdata
);

  typedef enum logic [2:0] {S_IDLE, S_CLR, S_SEND, S_RECV, S_RXCLR} state_t;
  state_t st;

  logic [7:0]    op_q;
  logic [CW-1:0] argc_q, rspc_q, argc_in, rspc_in;
  logic [AW-1:0] args_q, arg_sh;
  logic [IW-1:0] idx, idx_m1;
  logic [PW-1:0] poll;
  logic [7:0]    tx_byte;
  logic          waiting, ready, give_up, unused_lo;

  assign argc_in = (arg_cnt > CW'(MAX_BYTES)) ? CW'(MAX_BYTES) : arg_cnt;
  assign rspc_in = (rsp_cnt > CW'(MAX_BYTES)) ? CW'(MAX_BYTES) : rsp_cnt;

  assign idx_m1  = idx - 1'b1;
  assign arg_sh  = args_q >> {idx_m1, 3'b000};
  assign tx_byte = (idx == '0) ? op_q : arg_sh[7:0];

  assign busy          = (st != S_IDLE);
  assign mb_data_wr    = (st == S_SEND) && mb_stat[1];
  assign mb_data_wdata = {tx_byte, 8'h00};
  assign mb_data_rd    = (st == S_RECV) && mb_stat[2];
  assign mb_stat_wr    = (st == S_CLR) || (st == S_RXCLR);
  assign mb_stat_wdata = (st == S_CLR) ? mb_stat : 4'b0100;
  assign rsp_word      = {rsp_bytes[7:0], rsp_bytes[15:8]};
  assign unused_lo     = ^mb_data_rdata[7:0];

  assign waiting = (st == S_SEND) || (st == S_RECV);
  assign ready   = mb_data_wr || mb_data_rd;
  assign give_up = waiting && !ready && (poll == PW'(POLL_LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      op_q        <= '0;
      argc_q      <= '0;
      rspc_q      <= '0;
      args_q      <= '0;
      idx         <= '0;
      poll        <= '0;
      done        <= 1'b0;
      timeout_err <= 1'b0;
      ack_byte    <= '0;
      rsp_bytes   <= '0;
    end else begin
      done <= 1'b0;
      if (!waiting || ready) poll <= '0;
      else if (!give_up)     poll <= poll + 1'b1;

      if (give_up) begin
        st          <= S_IDLE;
        done        <= 1'b1;
        timeout_err <= 1'b1;
      end else begin
        case (st)
          S_IDLE: if (start) begin
            st          <= S_CLR;
            op_q        <= opcode;
            argc_q      <= argc_in;
            rspc_q      <= rspc_in;
            args_q      <= arg_bytes;
            idx         <= '0;
            timeout_err <= 1'b0;
            ack_byte    <= '0;
            rsp_bytes   <= '0;
          end
          S_CLR: st <= S_SEND;
          S_SEND: if (mb_data_wr) begin
            if (idx == IW'(argc_q)) begin
              st  <= S_RECV;
              idx <= '0;
            end else begin
              idx <= idx + 1'b1;
            end
          end
          S_RECV: if (mb_data_rd) begin
            if (idx == '0) ack_byte <= mb_data_rdata[15:8];
            for (int i = 0; i < MAX_BYTES; i++)
              if (idx == IW'(i + 1)) rsp_bytes[8*i +: 8] <= mb_data_rdata[15:8];
            idx <= idx + 1'b1;
            st  <= S_RXCLR;
          end
          S_RXCLR: begin
            if (idx == IW'(rspc_q) + 1'b1) begin
              st   <= S_IDLE;
              done <= 1'b1;
            end else begin
              st <= S_RECV;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/cmd_seq_chk.sv
module cmd_seq_chk #(
  parameter int POLL_LIMIT = 10000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic [3:0]  mb_stat,
  input logic        mb_stat_wr,
  input logic [3:0]  mb_stat_wdata,
  input logic        mb_data_wr,
  input logic        mb_data_rd
);

  localparam int RW = $clog2(POLL_LIMIT + 1) + 1;
  logic [RW-1:0] quiet_run;
  logic          quiet;

  assign quiet = busy && !mb_stat_wr && !mb_data_wr && !mb_data_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     quiet_run <= '0;
    else if (quiet) quiet_run <= quiet_run + 1'b1;
    else            quiet_run <= '0;
  end

  p_wr_room_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mb_data_wr |-> mb_stat[1]);

  p_rd_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mb_data_rd |-> mb_stat[2]);

  p_rx_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mb_data_rd |=> (mb_stat_wr && mb_stat_wdata == 4'b0100));

  p_first_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (mb_stat_wr && !mb_data_wr && !mb_data_rd));

  p_one_access_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mb_stat_wr, mb_data_wr, mb_data_rd}));

  p_poll_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |-> (quiet_run < RW'(POLL_LIMIT)));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_quiet_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mb_data_wr && !mb_data_rd && !mb_stat_wr));

endmodule

bind cmd_seq cmd_seq_chk #(.POLL_LIMIT(POLL_LIMIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .mb_stat(mb_stat),
  .mb_stat_wr(mb_stat_wr), .mb_stat_wdata(mb_stat_wdata),
  .mb_data_wr(mb_data_wr), .mb_data_rd(mb_data_rd)
);

// File: tb/tb_cmd_seq.sv
module tb_cmd_seq;
  localparam int CLK_PERIOD = 10;
  localparam int POLL = 16;

  logic clk = 0, rst_n = 0, start = 0;
  logic [7:0] opcode = 0;
  logic [3:0] arg_cnt = 0, rsp_cnt = 0;
  logic [63:0] arg_bytes = 0;
  logic busy, done, timeout_err;
  logic [7:0] ack_byte;
  logic [63:0] rsp_bytes;
  logic [15:0] rsp_word;
  logic [3:0] mb_stat, mb_stat_wdata;
  logic mb_stat_wr, mb_data_wr, mb_data_rd;
  logic [15:0] mb_data_wdata, mb_data_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_seq #(.MAX_BYTES(8), .POLL_LIMIT(POLL)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .arg_cnt(arg_cnt),
    .arg_bytes(arg_bytes), .rsp_cnt(rsp_cnt), .busy(busy), .done(done),
    .timeout_err(timeout_err), .ack_byte(ack_byte), .rsp_bytes(rsp_bytes),
    .rsp_word(rsp_word), .mb_stat(mb_stat), .mb_stat_wr(mb_stat_wr),
    .mb_stat_wdata(mb_stat_wdata), .mb_data_wr(mb_data_wr),
    .mb_data_wdata(mb_data_wdata), .mb_data_rd(mb_data_rd),
    .mb_data_rdata(mb_data_rdata));

  // mailbox model
  logic mdl_clr = 0, tx_block = 0;
  int rx_len = 0, dly = 0;
  logic [7:0] rxq [0:15];
  logic [7:0] tx_log [0:15];
  int tx_n, head, wait_c, clr_n, rxclr_n, done_n;
  logic ovf, lo_bad;
  logic [3:0] first_wd, first_st;
  logic rxne;

  assign rxne = (head < rx_len) && (wait_c == 0);
  assign mb_stat = {ovf, rxne, ~tx_block, ~tx_block};
  assign mb_data_rdata = {rxq[head[3:0]], 8'h5A};

  always @(posedge clk) begin
    if (mdl_clr) begin
      tx_n <= 0; head <= 0; wait_c <= dly; ovf <= 1; clr_n <= 0;
      rxclr_n <= 0; lo_bad <= 0; done_n <= 0; first_wd <= 0; first_st <= 0;
    end else begin
      if (done) done_n <= done_n + 1;
      if (wait_c != 0) wait_c <= wait_c - 1;
      if (mb_data_wr) begin
        if (tx_n < 16) tx_log[tx_n[3:0]] <= mb_data_wdata[15:8];
        tx_n <= tx_n + 1;
        if (mb_data_wdata[7:0] != 8'h00) lo_bad <= 1;
      end
      if (mb_data_rd) begin head <= head + 1; wait_c <= dly; end
      if (mb_stat_wr) begin
        clr_n <= clr_n + 1;
        if (clr_n == 0) begin first_wd <= mb_stat_wdata; first_st <= mb_stat; end
        else if (mb_stat_wdata == 4'b0100) rxclr_n <= rxclr_n + 1;
        if (mb_stat_wdata[3]) ovf <= 0;
      end
    end
  end

  int tests = 0, fails = 0, cyc = 0;
  logic wd = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) wd <= 1;
  end

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] abyte(int a, int i);
    return 8'((a * 16 + i * 3 + 1) & 255);
  endfunction
  function automatic logic [7:0] rbyte(int a, int r, int j);
    return 8'((a * 7 + r * 29 + j * 11 + 5) & 255);
  endfunction

  task automatic launch(input logic [7:0] op, input int a, input int r, input int nrx, input int d);
    @(negedge clk);
    dly = d; rx_len = nrx;
    for (int j = 0; j < 16; j++) rxq[j] = (j == 0) ? (op ^ 8'hA5) : rbyte(a, r, j - 1);
    opcode = op; arg_cnt = 4'(a); rsp_cnt = 4'(r);
    arg_bytes = '0;
    for (int i = 0; i < 8; i++) arg_bytes[8*i +: 8] = abyte(a, i);
    mdl_clr = 1;
    @(negedge clk);
    mdl_clr = 0; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_done;
    while (!done && !wd) @(negedge clk);
  endtask

  task automatic check_ok(input logic [7:0] op, input int a, input int r);
    int ae, re;
    logic [15:0] w;
    logic good;
    ae = (a > 8) ? 8 : a;
    re = (r > 8) ? 8 : r;
    chk(done === 1'b1 && timeout_err === 1'b0, "R11 done without timeout", {done, timeout_err}, 2'b10);
    chk(tx_n == ae + 1, (a > 8) ? "R8 arg clamp count" : "R7 tx count", tx_n, ae + 1);
    good = (tx_log[0] == op);
    for (int i = 0; i < ae; i++) if (tx_log[i+1] != abyte(a, i)) good = 0;
    chk(good, "R1 write order", tx_log[1], abyte(a, 0));
    chk(!lo_bad, "R2 low byte zero", lo_bad, 0);
    chk(ack_byte == (op ^ 8'hA5), "R6 ack byte", ack_byte, op ^ 8'hA5);
    good = 1;
    for (int j = 0; j < 8; j++)
      if (rsp_bytes[8*j +: 8] != ((j < re) ? rbyte(a, r, j) : 8'h00)) good = 0;
    chk(good, (r > 8) ? "R8 rsp clamp" : "R6 response bytes", rsp_bytes, rbyte(a, r, 0));
    w = {(re > 0) ? rbyte(a, r, 0) : 8'h00, (re > 1) ? rbyte(a, r, 1) : 8'h00};
    chk(rsp_word == w, "R6 rsp_word", rsp_word, w);
    chk(head == re + 1, "R1 reads consumed", head, re + 1);
    chk(rxclr_n == re + 1, "R4 rx clears", rxclr_n, re + 1);
    chk(first_wd == first_st && first_st[3], "R5 stale writeback", first_wd, first_st);
    @(negedge clk);
    chk(!done && !busy && done_n == 1, "R11 single done pulse", done_n, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !timeout_err && ack_byte == 0 && rsp_bytes == 0,
        "R12 reset state", {busy, done, timeout_err}, 0);
    rst_n = 1;
    @(negedge clk);

    for (int a = 0; a <= 8; a++)
      for (int r = 0; r <= 8; r++) begin
        launch(8'(8'h40 + a * 9 + r), a, r, r + 1, (a + r) % 4);
        wait_done;
        if (a == 0 && r == 0) chk(tx_n == 1 && head == 1, "R7 zero counts", tx_n, 1);
        check_ok(8'(8'h40 + a * 9 + r), a, r);
      end

    launch(8'h77, 11, 13, 9, 0);
    wait_done;
    check_ok(8'h77, 11, 13);

    launch(8'h21, 2, 3, 4, POLL - 4);
    wait_done;
    chk(!timeout_err, "R9 near-limit wait no abort", timeout_err, 0);
    check_ok(8'h21, 2, 3);

    launch(8'h31, 3, 2, 0, 0);
    wait_done;
    chk(timeout_err && tx_n == 4 && head == 0, "R9 rx timeout", {timeout_err, tx_n[3:0]}, 5'h14);
    @(negedge clk);
    chk(!busy && !done && timeout_err, "R9 timeout held idle", {busy, done, timeout_err}, 1);

    @(negedge clk); tx_block = 1;
    launch(8'h32, 1, 1, 2, 0);
    wait_done;
    chk(timeout_err && tx_n == 0, "R9 tx timeout", tx_n, 0);
    tx_block = 0;

    launch(8'h55, 4, 4, 5, 2);
    @(negedge clk);
    chk(!timeout_err, "R9 flag cleared on start", timeout_err, 0);
    repeat (3) @(negedge clk);
    opcode = 8'hEE; arg_cnt = 0; rsp_cnt = 0; start = 1;
    @(negedge clk); start = 0;
    opcode = 8'h55; arg_cnt = 4; rsp_cnt = 4;
    wait_done;
    check_ok(8'h55, 4, 4);
    repeat (5) @(negedge clk);
    chk(done_n == 1 && tx_n == 5 && !busy, "R10 start ignored while busy", done_n, 1);

    if (wd) chk(0, "watchdog", cyc, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule